// File: doc/BRIEF.md
# Coprocessor-to-Memory Transfer Sequencer

This block sits on the host side of a shared, multiplexed address/data bus. It moves a run of words from a coprocessor's registers into memory. A one-cycle start request supplies a coprocessor identifier, an operation code, a word count, an index value and an addressing mode. The block then runs a fixed sequence of phases: a command phase, a status slot, an address phase and a turnaround spacer. After these it hands the bus to the coprocessor for one data beat per word.

During the command phase the host drives the command word. In the status slot the host releases the bus and the block captures whatever status the coprocessor drives. The address phase presents the first beat's address and marks the row. The spacer keeps the host drivers off the bus for one full cycle, so the coprocessor never drives against them. Each data beat presents a column address and waits for ready.

The index is walked either upward after each beat or downward before each beat, one 32-bit word step at a time. The final index is returned together with a one-cycle done pulse.

Top module: `cop_xfer_seq`

## Requirements
- R1: With the block idle, a high `start_i` at a clock edge makes the next cycle the command phase (`phase_o`=1). In that cycle `bus_oe_o`=1 and `bus_o` = {id[31:29], mode[28], count field[27:23], op[22:15], zeros[14:0]}. `start_i` has no effect while a transfer is in progress.
- R2: The cycle after the command phase is the status slot (`phase_o`=2) with `bus_oe_o`=0. The value on `bus_i` at the end of that cycle appears on `status_o` from the next cycle on and is held until the next status slot.
- R3: The cycle after the status slot is the address phase (`phase_o`=3). In it `bus_oe_o`=1, `row_strobe_o`=1 and `bus_o` equals the first beat's address.
- R4: Exactly one spacer cycle (`phase_o`=4) follows the address phase, with `bus_oe_o`=0. The data phase (`phase_o`=5) follows the spacer and keeps `bus_oe_o`=0.
- R5: The number of data beats equals the count field, with 0 meaning 32. `col_strobe_o` is high in every data-phase cycle. A beat completes at a clock edge where `ready_i` is high.
- R6: In increment mode (`mode_i`=0), beat k (counted from 0) has address index+4k on `col_addr_o`, and the final index is index+4N.
- R7: In decrement mode (`mode_i`=1), beat k has address index−4(k+1), and the final index is index−4N. All arithmetic is modulo 2^32.
- R8: A data cycle with `ready_i` low completes no beat. The next cycle repeats the same column address and does not shorten the beat count.
- R9: `size32_o` is high in every non-idle phase and low when idle.
- R10: In the cycle after the last beat completes, the block is idle, `done_o` is high for that one cycle only, and `index_o` holds the final index until the next transfer ends.
- R11: After reset the block is idle (`phase_o`=0), with `bus_oe_o`, `done_o` and `size32_o` low and `index_o` and `status_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled when idle |
| cop_id_i | input | 3 | Coprocessor identifier |
| op_i | input | 8 | Operation code |
| count_i | input | 5 | Word count, 0 encodes 32 |
| index_i | input | 32 | Starting index (byte address) |
| mode_i | input | 1 | 0 = increment after beat, 1 = decrement before beat |
| ready_i | input | 1 | Beat ready; low stalls the current beat |
| bus_i | input | 32 | Value seen on the shared bus |
| bus_o | output | 32 | Value the host drives on the shared bus |
| bus_oe_o | output | 1 | Host bus driver enable |
| phase_o | output | 3 | Phase: 0 idle, 1 command, 2 status, 3 address, 4 spacer, 5 data |
| row_strobe_o | output | 1 | Row address marker (address phase) |
| col_strobe_o | output | 1 | Column marker, high for each data cycle |
| col_addr_o | output | 32 | Address of the current beat |
| size32_o | output | 1 | Full-width transfer indicator |
| status_o | output | 32 | Captured coprocessor status |
| done_o | output | 1 | One-cycle pulse after the last beat |
| index_o | output | 32 | Final index of the last transfer |

## Verification
All results are registered, so each one is due a whole number of cycles after its cause. The command phase is due one cycle after the start edge. The status slot, address phase and spacer follow at one cycle each, and the first data cycle comes four cycles after the command phase. Captured status is due in the address phase. The done pulse and the final index are due one cycle after the edge on which the last ready beat is taken. The bench drives inputs and samples outputs on the falling edge. It advances its expected beat number only on cycles where it drove ready high, so stalled cycles are compared against the unchanged address.

// File: rtl/cop_xfer_pkg.sv
package cop_xfer_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CMD    = 3'd1,
    ST_CSTAT  = 3'd2,
    ST_ADDR   = 3'd3,
    ST_SPACER = 3'd4,
    ST_DATA   = 3'd5
  } xfer_st_e;
endpackage

// File: rtl/cop_xfer_ctrl.sv
module cop_xfer_ctrl
  import cop_xfer_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             ready_i,
  output xfer_st_e         state_o,
  output logic             load_o,
  output logic             beat_done_o,
  output logic             last_o,
  output logic             done_o
);
  localparam int BEAT_W = CNT_W + 1;
  localparam logic [BEAT_W-1:0] MAX_BEATS = BEAT_W'(1) << CNT_W;

  xfer_st_e          state_q, state_d;
  logic [BEAT_W-1:0] total_q, beat_q;
  logic              done_q;

  assign load_o      = (state_q == ST_IDLE) && start_i;
  assign beat_done_o = (state_q == ST_DATA) && ready_i;
  assign last_o      = (beat_q == total_q - BEAT_W'(1));

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (start_i) state_d = ST_CMD;
      ST_CMD:    state_d = ST_CSTAT;
      ST_CSTAT:  state_d = ST_ADDR;
      ST_ADDR:   state_d = ST_SPACER;
      ST_SPACER: state_d = ST_DATA;
      ST_DATA:   if (beat_done_o && last_o) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      total_q <= '0;
      beat_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= beat_done_o && last_o;
      if (load_o) begin
        total_q <= (count_i == '0) ? MAX_BEATS : {1'b0, count_i};
        beat_q  <= '0;
      end else if (beat_done_o) begin
        beat_q  <= beat_q + BEAT_W'(1);
      end
    end
  end

  assign state_o = state_q;
  assign done_o  = done_q;

  assert_data_after_spacer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> ($past(state_q) == ST_SPACER || $past(state_q) == ST_DATA));
  assert_beat_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (beat_q < total_q));
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
endmodule

// File: rtl/cop_xfer_index.sv
module cop_xfer_index #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic              beat_done_i,
  input  logic              last_i,
  output logic [ADDR_W-1:0] col_addr_o,
  output logic [ADDR_W-1:0] result_o
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic              mode_q;
  logic [ADDR_W-1:0] idx_q, idx_next, result_q;

  assign idx_next   = mode_q ? (idx_q - STEP_V) : (idx_q + STEP_V);
  // decrement mode forms the address after stepping down
  assign col_addr_o = mode_q ? (idx_q - STEP_V) : idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      idx_q    <= '0;
      result_q <= '0;
    end else begin
      if (load_i) begin
        mode_q <= mode_i;
        idx_q  <= index_i;
      end else if (beat_done_i) begin
        idx_q  <= idx_next;
        if (last_i) result_q <= idx_next;
      end
    end
  end

  assign result_o = result_q;

  assert_stall_holds_index_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !beat_done_i) |=> $stable(idx_q));
  assert_result_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(beat_done_i && last_i) |=> $stable(result_q));
endmodule

// File: rtl/cop_xfer_bus.sv
module cop_xfer_bus
  import cop_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 3,
  parameter int OP_W   = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_st_e          state_i,
  input  logic              load_i,
  input  logic [ID_W-1:0]   cop_id_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] col_addr_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [2:0]        phase_o,
  output logic              row_strobe_o,
  output logic              col_strobe_o,
  output logic              size32_o,
  output logic [DATA_W-1:0] status_o
);
  localparam int PAD_W = DATA_W - ID_W - 1 - CNT_W - OP_W;

  logic [DATA_W-1:0] cmd_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      status_q <= '0;
    end else begin
      if (load_i) cmd_q <= {cop_id_i, mode_i, count_i, op_i, {PAD_W{1'b0}}};
      if (state_i == ST_CSTAT) status_q <= bus_i;
    end
  end

  always_comb begin
    bus_o    = '0;
    bus_oe_o = 1'b0;
    unique case (state_i)
      ST_CMD:  begin bus_o = cmd_q;      bus_oe_o = 1'b1; end
      ST_ADDR: begin bus_o = col_addr_i; bus_oe_o = 1'b1; end
      default: ;
    endcase
  end

  assign phase_o      = state_i;
  assign row_strobe_o = (state_i == ST_ADDR);
  assign col_strobe_o = (state_i == ST_DATA);
  assign size32_o     = (state_i != ST_IDLE);
  assign status_o     = status_q;

  assert_status_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_CSTAT) |=> $stable(status_q));
  assert_bus_released_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_SPACER || state_i == ST_DATA || state_i == ST_CSTAT) |-> !bus_oe_o);
  assert_cmd_stable_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i != ST_IDLE) |=> $stable(cmd_q));
endmodule

// File: rtl/cop_xfer_seq.sv
module cop_xfer_seq
  import cop_xfer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 3,
  parameter int OP_W   = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ID_W-1:0]   cop_id_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [DATA_W-1:0] index_i,
  input  logic              mode_i,
  input  logic              ready_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic [2:0]        phase_o,
  output logic              row_strobe_o,
  output logic              col_strobe_o,
  output logic [DATA_W-1:0] col_addr_o,
  output logic              size32_o,
  output logic [DATA_W-1:0] status_o,
  output logic              done_o,
  output logic [DATA_W-1:0] index_o
);
  localparam int STEP = DATA_W / 8;

  xfer_st_e          state;
  logic              load, beat_done, last;
  logic [DATA_W-1:0] col_addr;

  cop_xfer_ctrl #(.CNT_W(CNT_W)) ctrl_i (
    .clk_i, .rst_ni, .start_i, .count_i, .ready_i,
    .state_o(state), .load_o(load), .beat_done_o(beat_done),
    .last_o(last), .done_o
  );

  cop_xfer_index #(.ADDR_W(DATA_W), .STEP(STEP)) index_i_u (
    .clk_i, .rst_ni, .load_i(load), .mode_i, .index_i,
    .beat_done_i(beat_done), .last_i(last),
    .col_addr_o(col_addr), .result_o(index_o)
  );

  cop_xfer_bus #(.DATA_W(DATA_W), .ID_W(ID_W), .OP_W(OP_W), .CNT_W(CNT_W)) bus_u (
    .clk_i, .rst_ni, .state_i(state), .load_i(load),
    .cop_id_i, .op_i, .count_i, .mode_i,
    .col_addr_i(col_addr), .bus_i,
    .bus_o, .bus_oe_o, .phase_o, .row_strobe_o, .col_strobe_o,
    .size32_o, .status_o
  );

  assign col_addr_o = col_addr;

  assert_size_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_IDLE) |-> size32_o);
  assert_start_ignored_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DATA && start_i && !(beat_done && last)) |=> (state == ST_DATA));
endmodule

// File: tb/cop_xfer_seq_tb_top.sv
module cop_xfer_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cop_id = '0;
  logic [7:0]  op = '0;
  logic [4:0]  count = '0;
  logic [31:0] index = '0;
  logic        mode = 1'b0;
  logic        ready = 1'b0;
  logic [31:0] bus_in = '0;
  logic [31:0] bus_out, col_addr, status, index_out;
  logic        bus_oe, row_strobe, col_strobe, size32, done;
  logic [2:0]  phase;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cop_xfer_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cop_id_i(cop_id), .op_i(op),
    .count_i(count), .index_i(index), .mode_i(mode), .ready_i(ready), .bus_i(bus_in),
    .bus_o(bus_out), .bus_oe_o(bus_oe), .phase_o(phase), .row_strobe_o(row_strobe),
    .col_strobe_o(col_strobe), .col_addr_o(col_addr), .size32_o(size32),
    .status_o(status), .done_o(done), .index_o(index_out)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] beat_addr(input logic [31:0] idx, input logic m, input int k);
    return m ? idx - 32'(4 * (k + 1)) : idx + 32'(4 * k);
  endfunction

  function automatic logic [31:0] final_idx(input logic [31:0] idx, input logic m, input int n);
    return m ? idx - 32'(4 * n) : idx + 32'(4 * n);
  endfunction

  task automatic xfer(input logic [2:0] id, input logic [7:0] oc, input logic [4:0] cnt,
                      input logic [31:0] idx, input logic m, input int stall_pct);
    int n;
    int k;
    logic [31:0] st;
    logic prev_stall;
    n  = (cnt == 0) ? 32 : int'(cnt);
    st = $urandom;
    @(negedge clk);
    cop_id = id; op = oc; count = cnt; index = idx; mode = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cop_id = ~id; count = ~cnt; index = ~idx;
    chk("R1", "cmd phase", 32'(phase), 32'd1);
    chk("R1", "cmd oe", 32'(bus_oe), 32'd1);
    chk("R1", "cmd word", bus_out, {id, m, cnt, oc, 15'd0});
    chk("R9", "size cmd", 32'(size32), 32'd1);
    bus_in = st;
    @(negedge clk);
    chk("R2", "status phase", 32'(phase), 32'd2);
    chk("R2", "status oe", 32'(bus_oe), 32'd0);
    @(negedge clk);
    bus_in = ~st;
    chk("R2", "status captured", status, st);
    chk("R3", "addr phase", 32'(phase), 32'd3);
    chk("R3", "addr oe", 32'(bus_oe), 32'd1);
    chk("R3", "row strobe", 32'(row_strobe), 32'd1);
    chk(m ? "R7" : "R6", "addr value", bus_out, beat_addr(idx, m, 0));
    @(negedge clk);
    chk("R4", "spacer phase", 32'(phase), 32'd4);
    chk("R4", "spacer oe", 32'(bus_oe), 32'd0);
    k = 0;
    prev_stall = 1'b0;
    while (k < n) begin
      @(negedge clk);
      chk("R4", "data phase", 32'(phase), 32'd5);
      chk("R4", "data oe", 32'(bus_oe), 32'd0);
      chk("R5", "col strobe", 32'(col_strobe), 32'd1);
      chk("R9", "size data", 32'(size32), 32'd1);
      chk(prev_stall ? "R8" : (m ? "R7" : "R6"), "col addr", col_addr, beat_addr(idx, m, k));
      chk("R2", "status held", status, st);
      ready = ($urandom % 100) >= 32'(stall_pct);
      start = $urandom % 2;
      prev_stall = !ready;
      if (ready) k++;
    end
    @(negedge clk);
    start = 1'b0;
    ready = 1'b0;
    chk("R10", "idle after last", 32'(phase), 32'd0);
    chk("R10", "done pulse", 32'(done), 32'd1);
    chk(m ? "R7" : "R6", "final index", index_out, final_idx(idx, m, n));
    chk("R9", "size idle", 32'(size32), 32'd0);
    @(negedge clk);
    chk("R10", "done one cycle", 32'(done), 32'd0);
    chk("R1", "no restart from busy start", 32'(phase), 32'd0);
    chk("R10", "index held", index_out, final_idx(idx, m, n));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20250));
    repeat (3) @(negedge clk);
    chk("R11", "reset phase", 32'(phase), 32'd0);
    chk("R11", "reset oe", 32'(bus_oe), 32'd0);
    chk("R11", "reset done", 32'(done), 32'd0);
    chk("R11", "reset size", 32'(size32), 32'd0);
    chk("R11", "reset index", index_out, 32'd0);
    chk("R11", "reset status", status, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "idle without start", 32'(phase), 32'd0);
    // directed corners
    xfer(3'd5, 8'hA5, 5'd0, 32'h0000_1000, 1'b0, 0);    // R5: zero count means 32
    xfer(3'd2, 8'h3C, 5'd1, 32'h0000_0000, 1'b1, 0);    // R7: wrap below zero
    xfer(3'd7, 8'hFF, 5'd31, 32'hFFFF_FFF0, 1'b0, 60);  // R6, R8: wrap above, heavy stall
    xfer(3'd1, 8'h01, 5'd0, 32'h8000_0000, 1'b1, 30);   // R7 with 32 beats
    for (int i = 0; i < 24; i++)
      xfer(3'($urandom), 8'($urandom), 5'($urandom), $urandom, 1'($urandom), int'($urandom % 50));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule